// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This block is a small multicycle processor whose program is made of one kind of instruction. No opcode field exists. Every instruction occupies three consecutive words, `a`, `b` and `c`, in a single memory that holds both code and data. Execution subtracts the word at `a` from the word at `b` and stores the difference back at `b`. If the difference, read as a signed number, is zero or below, the program counter jumps to `c`. Otherwise it moves on to the next three-word instruction.

A host loads a program and its data through a simple memory port while the core is idle or halted. It then pulses `start`, and later reads the results back through the same port. The core stops and raises `halted` in two cases: a taken branch names a negative target, or the program counter points at an instruction that would not fit inside the memory. A running cycle count reports how many clock cycles the program consumed.

Top module: `one_op_cpu`

## Requirements
- R1: After reset `halted` = 0, `busy` = 0 and `cycles` = 0. A `start` pulse accepted while idle or halted sets the program counter to address 0 and clears `cycles`.
- R2: The instruction at program counter `p` is read from words `p` (a), `p+1` (b) and `p+2` (c). The core writes `mem[b] - mem[a]` back to `b`, computed modulo 2^16. Only the low ADDR_W bits of `a` and `b` select the memory word.
- R3: The word at address `a` keeps its value unless `a` and `b` select the same word, in which case that word becomes 0.
- R4: When the difference is zero or negative (two's complement) and `c` is non-negative, the next instruction is fetched from `c`.
- R5: When the difference is strictly positive, the next instruction is fetched from program counter + 3.
- R6: When the difference is zero or negative and `c` has its sign bit set, the write to `b` still happens. The core then halts and makes no further memory writes.
- R7: When the program counter is above DEPTH-3 at the start of an instruction, the core halts in that cycle without any memory write.
- R8: Every executed instruction takes exactly 7 cycles. A halt caused by the program counter range adds 1 cycle. `cycles` counts running cycles: k clock edges after the edge that accepts `start`, it reads min(k, T), where T is the run's total cycle count.
- R9: While the core is not running, a `host_we` edge writes `host_wdata` to `host_addr`, and `host_rdata` shows `mem[host_addr]` one clock edge after the address is presented. While the core is running, `host_we` has no effect on memory.
- R10: A `start` pulse while the core is running is ignored.
- R11: `halted` rises at the edge that ends the last running cycle. It stays high until `start` is accepted, and it is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 when not running |
| busy | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped after a run |
| cycles | output | CNT_W | Running-cycle count of the current or last run |
| host_we | input | 1 | Host write strobe, honoured only while not running |
| host_addr | input | ADDR_W | Host memory address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Memory word read one edge after the address |

## Verification
The bench counts edges from the one that accepts `start`. After edge k it expects `cycles` = min(k, T), `halted` = (k ≥ T) and `busy` = (k < T), where T = 7·N plus 1 for a range halt. A behavioural model of the instruction set supplies N and the final memory image. These three outputs are compared at the falling edge after every clock during each run, so an off-by-one in state sequencing or halt timing shows up as a wrong value in a specific cycle. Memory results are read back after the halt, with `host_rdata` sampled one full clock after the address is set.

// File: rtl/one_op_pkg.sv
package one_op_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_READ_A,
    ST_READ_B,
    ST_WRITE_B,
    ST_NEXT,
    ST_HALT
  } core_state_t;

  localparam int unsigned INSTR_WORDS = 3;

  function automatic logic is_running(input core_state_t s);
    return (s != ST_IDLE) && (s != ST_HALT);
  endfunction

endpackage

// File: rtl/one_op_ram.sv
module one_op_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Read-before-write single port, one cycle read latency.
  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
    end
    rdata <= store[addr];
  end

endmodule

// File: rtl/one_op_sub.sv
module one_op_sub #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output logic              not_positive
);
  always_comb begin
    diff         = minuend - subtrahend;
    not_positive = diff[DATA_W-1] | (diff == '0);
  end
endmodule

// File: rtl/one_op_ctrl.sv
module one_op_ctrl
  import one_op_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              halted,
  output logic [CNT_W-1:0]  cycles,
  output logic [DATA_W-1:0] pc_o
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned LAST_PC = DEPTH - INSTR_WORDS;
  localparam logic [DATA_W-1:0] LAST_PC_W = DATA_W'(LAST_PC);
  localparam logic [DATA_W-1:0] STEP_W    = DATA_W'(INSTR_WORDS);

  core_state_t state_q, state_n;

  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] addr_a_q, addr_b_q, target_q;
  logic [DATA_W-1:0] val_a_q;
  logic              take_q;
  logic              busy_q, halted_q;
  logic [CNT_W-1:0]  cycles_q;

  logic [DATA_W-1:0] pc_plus1, pc_plus2;
  logic              pc_fits;
  logic [DATA_W-1:0] diff;
  logic              not_pos;

  assign pc_plus1 = pc_q + DATA_W'(1);
  assign pc_plus2 = pc_q + DATA_W'(2);
  assign pc_fits  = (pc_q <= LAST_PC_W);

  one_op_sub #(.DATA_W(DATA_W)) u_sub (
    .minuend      (rdata),
    .subtrahend   (val_a_q),
    .diff         (diff),
    .not_positive (not_pos)
  );

  // Next state and memory request.
  always_comb begin
    state_n   = state_q;
    mem_addr  = pc_q[ADDR_W-1:0];
    mem_we    = 1'b0;
    mem_wdata = diff;
    unique case (state_q)
      ST_IDLE, ST_HALT: begin
        if (start) state_n = ST_FETCH_A;
      end
      ST_FETCH_A: begin
        mem_addr = pc_q[ADDR_W-1:0];
        state_n  = pc_fits ? ST_FETCH_B : ST_HALT;
      end
      ST_FETCH_B: begin
        mem_addr = pc_plus1[ADDR_W-1:0];
        state_n  = ST_FETCH_C;
      end
      ST_FETCH_C: begin
        mem_addr = pc_plus2[ADDR_W-1:0];
        state_n  = ST_READ_A;
      end
      ST_READ_A: begin
        mem_addr = addr_a_q[ADDR_W-1:0];
        state_n  = ST_READ_B;
      end
      ST_READ_B: begin
        mem_addr = addr_b_q[ADDR_W-1:0];
        state_n  = ST_WRITE_B;
      end
      ST_WRITE_B: begin
        mem_addr = addr_b_q[ADDR_W-1:0];
        mem_we   = 1'b1;
        state_n  = ST_NEXT;
      end
      ST_NEXT: begin
        state_n = (take_q && target_q[DATA_W-1]) ? ST_HALT : ST_FETCH_A;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // State, operand capture and program counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      addr_a_q <= '0;
      addr_b_q <= '0;
      target_q <= '0;
      val_a_q  <= '0;
      take_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start) pc_q <= '0;
        end
        ST_FETCH_B: addr_a_q <= rdata;
        ST_FETCH_C: addr_b_q <= rdata;
        ST_READ_A:  target_q <= rdata;
        ST_READ_B:  val_a_q  <= rdata;
        ST_WRITE_B: take_q   <= not_pos;
        ST_NEXT: begin
          if (take_q) begin
            if (!target_q[DATA_W-1]) pc_q <= target_q;
          end else begin
            pc_q <= pc_q + STEP_W;
          end
        end
        default: ;
      endcase
    end
  end

  // Registered status outputs and running-cycle counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      halted_q <= 1'b0;
      cycles_q <= '0;
    end else begin
      busy_q   <= is_running(state_n);
      halted_q <= (state_n == ST_HALT);
      if ((state_q == ST_IDLE || state_q == ST_HALT) && start) begin
        cycles_q <= '0;
      end else if (is_running(state_q)) begin
        cycles_q <= cycles_q + CNT_W'(1);
      end
    end
  end

  assign busy   = busy_q;
  assign halted = halted_q;
  assign cycles = cycles_q;
  assign pc_o   = pc_q;

endmodule

// File: rtl/one_op_cpu.sv
module one_op_cpu
  import one_op_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              halted,
  output logic [CNT_W-1:0]  cycles,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic [ADDR_W-1:0] core_addr;
  logic              core_we;
  logic [DATA_W-1:0] core_wdata;
  logic [DATA_W-1:0] core_pc;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  one_op_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rdata     (ram_rdata),
    .mem_addr  (core_addr),
    .mem_we    (core_we),
    .mem_wdata (core_wdata),
    .busy      (busy),
    .halted    (halted),
    .cycles    (cycles),
    .pc_o      (core_pc)
  );

  // The host owns the single port whenever the core is not running.
  always_comb begin
    if (busy) begin
      ram_addr  = core_addr;
      ram_we    = core_we;
      ram_wdata = core_wdata;
    end else begin
      ram_addr  = host_addr;
      ram_we    = host_we;
      ram_wdata = host_wdata;
    end
  end

  one_op_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign host_rdata = ram_rdata;

endmodule

// File: rtl/one_op_cpu_checks.sv
module one_op_cpu_checks #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              halted,
  input logic [CNT_W-1:0]  cycles,
  input logic              core_we,
  input logic [DATA_W-1:0] core_pc
);

  // R1: accepted start resets the program counter
  assert_start_pc_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (core_pc == '0));

  // R2: at most one write per instruction
  assert_single_write_R2: assert property (@(posedge clk) disable iff (rst)
    core_we |=> !core_we);

  // R6: no write once halted
  assert_halt_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    halted |-> !core_we);

  // R8: counter advances on every running cycle
  assert_cycles_step_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cycles == $past(cycles) + CNT_W'(1)));

  // R8: counter frozen when not running and not restarted
  assert_cycles_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cycles));

  // R11: halted and busy exclusive
  assert_excl_status_R11: assert property (@(posedge clk) disable iff (rst)
    !(busy && halted));

  // R11: halted held until start
  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> halted);

endmodule

bind one_op_cpu one_op_cpu_checks #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_checks (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .halted  (halted),
  .cycles  (cycles),
  .core_we (core_we),
  .core_pc (core_pc)
);

// File: tb/one_op_cpu_test.sv
module one_op_cpu_test;
  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int CW    = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          busy, halted;
  logic [CW-1:0] cycles;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] img [DEPTH];
  logic [DW-1:0] mdl [DEPTH];

  always #5 clk = ~clk;

  one_op_cpu #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .halted     (halted),
    .cycles     (cycles),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) img[i] = '0;
  endtask

  task automatic put(input int at, input logic [DW-1:0] a, input logic [DW-1:0] b,
                     input logic [DW-1:0] c);
    img[at] = a; img[at+1] = b; img[at+2] = c;
  endtask

  task automatic load_img();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(i); host_wdata = img[i];
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic peek(input int at, output logic [DW-1:0] val);
    @(negedge clk);
    host_we = 1'b0; host_addr = AW'(at);
    @(negedge clk);
    val = host_rdata;
  endtask

  // Behavioural model of the instruction set: returns executed count and halt kind.
  task automatic model(output int n, output bit range_halt);
    int pc;
    logic [DW-1:0] a, b, c, d;
    for (int i = 0; i < DEPTH; i++) mdl[i] = img[i];
    pc = 0; n = 0; range_halt = 1'b0;
    while (n < 10000) begin
      if (pc > DEPTH - 3) begin range_halt = 1'b1; break; end
      a = mdl[pc]; b = mdl[pc+1]; c = mdl[pc+2];
      d = mdl[b[AW-1:0]] - mdl[a[AW-1:0]];
      mdl[b[AW-1:0]] = d;
      n++;
      if ($signed(d) <= 0) begin
        if (c[DW-1]) break;
        pc = int'(c);
      end else begin
        pc = pc + 3;
      end
    end
  endtask

  task automatic run(input string mem_tag, input string halt_tag, input string cyc_tag,
                     input bit disturb);
    int n, t, expc;
    bit rh;
    logic [DW-1:0] v;
    model(n, rh);
    t = 7 * n + (rh ? 1 : 0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 cycles cleared", 64'(cycles), 64'd0);
    for (int k = 1; k <= t + 3; k++) begin
      if (disturb && k == 10) begin
        host_we = 1'b1; host_addr = AW'(200); host_wdata = 16'hDEAD;
      end
      if (disturb && k == 11) host_we = 1'b0;
      if (disturb && k == 12) start = 1'b1;
      if (disturb && k == 13) start = 1'b0;
      @(negedge clk);
      expc = (k < t) ? k : t;
      check(cyc_tag, 64'(cycles), 64'(expc));
      check(halt_tag, 64'(halted), 64'(k >= t));
      check("R11 busy", 64'(busy), 64'(k < t));
    end
    for (int i = 0; i < DEPTH; i++) begin
      peek(i, v);
      check(mem_tag, 64'(v), 64'(mdl[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 halted after reset", 64'(halted), 64'd0);
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 cycles after reset", 64'(cycles), 64'd0);

    // R9: idle host write and one-edge read latency
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(50); host_wdata = 16'h5A5A;
    @(negedge clk);
    host_we = 1'b0;
    peek(50, v);
    check("R9 idle write readback", 64'(v), 64'h5A5A);

    // R3 and R6: addition by three instructions, halt on negative target
    clear_img();
    put(0, 16'd102, 16'd102, 16'd3);
    img[0] = 16'd100;
    put(3, 16'd102, 16'd101, 16'd6);
    put(6, 16'd102, 16'd102, 16'hFFFF);
    img[100] = 16'd5; img[101] = 16'd7; img[102] = 16'd0;
    load_img();
    run("R3 add result", "R6 negative target halt", "R8 cycles add", 1'b0);

    // R4 and R10: countdown loop with host write and start disturbance mid-run
    clear_img();
    put(0, 16'd111, 16'd110, 16'd6);
    put(3, 16'd112, 16'd112, 16'd0);
    put(6, 16'd112, 16'd112, 16'hFFFF);
    img[110] = 16'd4; img[111] = 16'd1; img[200] = 16'h1234;
    load_img();
    run("R4 loop memory", "R6 loop halt", "R10 cycles with start pulse", 1'b1);
    peek(200, v);
    check("R9 host write while running ignored", 64'(v), 64'h1234);

    // R5 and R7: fall through past the end of memory
    clear_img();
    put(0, 16'd112, 16'd112, 16'd253);
    put(253, 16'd111, 16'd113, 16'd0);
    img[111] = 16'd1; img[113] = 16'd5;
    load_img();
    run("R5 fall through memory", "R7 range halt", "R8 cycles range halt", 1'b0);

    // R7: branch straight to an address that cannot hold an instruction
    clear_img();
    put(0, 16'd112, 16'd112, 16'd254);
    img[112] = 16'd9;
    load_img();
    run("R7 jump out memory", "R7 jump out halt", "R8 cycles jump out", 1'b0);

    // R2: signed wrap and high operand address bits ignored
    clear_img();
    put(0, 16'h0165, 16'h0164, 16'hFFFF);
    put(3, 16'd112, 16'd112, 16'hFFFF);
    img[100] = 16'h8000; img[101] = 16'd1;
    load_img();
    run("R2 wrap memory", "R6 wrap halt", "R8 cycles wrap", 1'b0);
    peek(100, v);
    check("R2 wrapped difference", 64'(v), 64'h7FFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule